// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps calendar time in packed BCD: seconds, minutes, 24-hour hours, day of week, date, month and a two-digit year. Software reaches it through eight bytes at the top of a byte-wide address space. It uses a synchronous port with address, write data, write strobe and read data. An external one-pulse-per-second tick advances the live counters. The `osc_stop` output gates the oscillator that produces that tick.

Software never reads the live counters directly. It reads a shadow copy, which the block refreshes from the counters one cycle after each accepted tick. A control byte holds two halt bits:

- One freezes the shadow so that software gets a coherent read while the counters keep running.
- The other freezes the shadow so that software can load a new time. Clearing this bit commits the seven shadow bytes into the live counters.

The control byte also stores a signed calibration value that a prescaler outside this block consumes.

Top module: `rtc_shadow_bank`

## Requirements
- R1: The window is the eight highest addresses. The offset inside the window is `addr[2:0]`: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A read outside the window returns 0x00. A write outside the window changes no register.
- R2: After reset the time reads 00:00:00, day 01, date 01, month 01, year 00. The seconds byte reads 0x80 (stop set), the control byte reads 0x00, and `osc_stop` is 1.
- R3: Bit 7 of the seconds byte is the stop flag and drives `osc_stop`. While it is 1, ticks are ignored. After software writes it to 0, the next tick advances the count.
- R4: Unused bits read as zero whatever is written. The masks are: minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF, seconds value 0x7F.
- R5: An accepted tick advances the live counters at that clock edge, and the shadow shows the new time one cycle later. Read data is registered and shows the addressed byte one cycle after the address.
- R6: Seconds and minutes count 00 to 59 in BCD and carry into the next field on wrap. Hours count 00 to 23 in BCD.
- R7: Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by four (including 00) and 28 days otherwise. All other months have 31 days.
- R8: One tick at 23:59:59 on the last day of a month sets date 01 and advances the day of week (07 wraps to 01) and the month. After month 12 it advances the year, and 99 wraps to 00.
- R9: While control bit 6 (READ) is 1, the shadow holds its value and the live counters keep counting. After READ is cleared, the next tick shows the live count.
- R10: While control bit 7 (WRITE) is 1, the shadow is not refreshed. A control write that takes WRITE from 1 to 0 loads all seven time bytes into the live counters. A tick in that same cycle is discarded.
- R11: With READ and WRITE both 1 there is no refresh. Clearing only READ while WRITE stays 1 commits nothing and does not refresh.
- R12: A tick accepted while both halt bits are 0 completes its shadow refresh, even when a halt bit is written in that same cycle.
- R13: The control byte reads back exactly what was written, including the calibration sign (bit 5) and the magnitude (bits 4 to 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse per second |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
A wrong live-counter state stays hidden while a halt bit is set. It surfaces one cycle after the next refresh, so every sweep step reads the fields back after its tick. A wrong month-length decision shows only at a last-day rollover. The bench therefore loads each month's last day directly, for every year in the February sweep, and ticks once. A wrong commit or halt decision shows as a shadow value that is off by one or more seconds on the first read after the next tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned WIN_BYTES = 8;
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES);

  // byte k-1 of the packed vector is window offset k
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME =
    rtc_time_t'({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    case (mon)
      8'h02:                      return (s[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] byte_mask(input logic [OFF_W-1:0] off);
    case (off)
      3'd1:    return 8'h7F;
      3'd2:    return 8'h7F;
      3'd3:    return 8'h3F;
      3'd4:    return 8'h07;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rtc_live_count.sv
module rtc_live_count
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t time_o
);

  rtc_time_t cur_q, cur_d;
  logic [7:0] last_date;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;

  always_comb begin
    last_date = month_last(cur_q.month, cur_q.year);
    s_wrap  = (cur_q.second == 8'h59);
    m_wrap  = s_wrap && (cur_q.minute == 8'h59);
    h_wrap  = m_wrap && (cur_q.hour == 8'h23);
    d_wrap  = h_wrap && (cur_q.date == last_date);
    mo_wrap = d_wrap && (cur_q.month == 8'h12);
  end

  always_comb begin
    cur_d = cur_q;
    if (load_i) begin
      cur_d = load_val_i;
    end else if (step_i) begin
      cur_d.second = s_wrap ? 8'h00 : bcd_inc(cur_q.second);
      if (s_wrap) cur_d.minute = m_wrap ? 8'h00 : bcd_inc(cur_q.minute);
      if (m_wrap) cur_d.hour   = h_wrap ? 8'h00 : bcd_inc(cur_q.hour);
      if (h_wrap) begin
        cur_d.dow  = (cur_q.dow == 8'h07) ? 8'h01 : bcd_inc(cur_q.dow);
        cur_d.date = d_wrap ? 8'h01 : bcd_inc(cur_q.date);
      end
      if (d_wrap)  cur_d.month = mo_wrap ? 8'h01 : bcd_inc(cur_q.month);
      if (mo_wrap) cur_d.year  = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur_q <= RTC_RESET_TIME;
    else if (step_i || load_i) cur_q <= cur_d;
  end

  assign time_o = cur_q;

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !load_i |=> $stable(time_o)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> time_o == $past(load_val_i)); // R10
  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && time_o.second == 8'h59 |=> time_o.second == 8'h00); // R6
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && time_o.dow == 8'h07 && time_o.hour == 8'h23 &&
    time_o.minute == 8'h59 && time_o.second == 8'h59 |=> time_o.dow == 8'h01); // R8

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_hit_i,
  input  logic [OFF_W-1:0] rd_off_i,
  input  logic             tick_i,
  input  rtc_time_t        live_i,
  output logic [7:0]       rd_data_o,
  output rtc_time_t        shadow_o,
  output logic             commit_o,
  output logic             step_o,
  output logic             stop_o
);

  localparam int unsigned TIME_BYTES = WIN_BYTES - 1;

  logic [7:0] ctrl_q, ctrl_d;
  logic       stop_q, stop_d;
  logic       upd_go_q, upd_go_d;
  logic [7:0] rd_q, rd_d;
  logic [8*TIME_BYTES-1:0] live_vec, shd_vec;
  logic       wr_ctrl, wr_sec;

  assign live_vec = live_i;
  assign wr_ctrl  = wr_en_i && (wr_off_i == '0);
  assign wr_sec   = wr_en_i && (wr_off_i == OFF_W'(1));

  // commit on the 1-to-0 transition of the WRITE bit
  assign commit_o = wr_ctrl && ctrl_q[7] && !wr_data_i[7];
  assign step_o   = tick_i && !stop_q && !commit_o;

  always_comb begin
    ctrl_d   = wr_ctrl ? wr_data_i : ctrl_q;
    stop_d   = wr_sec ? wr_data_i[7] : stop_q;
    upd_go_d = step_o && !ctrl_q[7] && !ctrl_q[6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= 8'h00;
      stop_q   <= 1'b1;
      upd_go_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      stop_q   <= stop_d;
      upd_go_q <= upd_go_d;
    end
  end

  for (genvar k = 1; k < WIN_BYTES; k++) begin : g_byte
    localparam logic [OFF_W-1:0] OFF = OFF_W'(k);
    logic [7:0] q, d;
    logic       en;
    always_comb begin
      en = upd_go_q || (wr_en_i && wr_off_i == OFF);
      d  = upd_go_q ? (live_vec[(k-1)*8 +: 8] & byte_mask(OFF))
                    : (wr_data_i & byte_mask(OFF));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RTC_RESET_TIME[(k-1)*8 +: 8];
      else if (en) q <= d;
    end
    assign shd_vec[(k-1)*8 +: 8] = q;
  end

  assign shadow_o = rtc_time_t'(shd_vec);

  always_comb begin
    rd_d = 8'h00;
    if (rd_hit_i) begin
      case (rd_off_i)
        3'd0:    rd_d = ctrl_q;
        3'd1:    rd_d = {stop_q, shd_vec[6:0]};
        default: rd_d = shd_vec[{rd_off_i - 3'd1, 3'b000} +: 8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'h00;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign stop_o    = stop_q;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] || ctrl_q[6]) && !upd_go_q && !wr_en_i |=> $stable(shadow_o)); // R9
  AST_REFRESH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go_q |=> shadow_o.second == ($past(live_i.second) & 8'h7F)); // R5
  AST_REFRESH_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go_q |=> shadow_o.year == $past(live_i.year)); // R5
  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit_i |=> rd_data_o == 8'h00); // R1

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              sec_tick,
  output logic              osc_stop
);

  logic             win_hit;
  logic [OFF_W-1:0] win_off;
  logic             commit, step;
  rtc_time_t        live_time, shadow_time;

  assign win_hit = &addr[ADDR_W-1:OFF_W];
  assign win_off = addr[OFF_W-1:0];

  rtc_shadow_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en && win_hit),
    .wr_off_i  (win_off),
    .wr_data_i (wr_data),
    .rd_hit_i  (win_hit),
    .rd_off_i  (win_off),
    .tick_i    (sec_tick),
    .live_i    (live_time),
    .rd_data_o (rd_data),
    .shadow_o  (shadow_time),
    .commit_o  (commit),
    .step_o    (step),
    .stop_o    (osc_stop)
  );

  rtc_live_count u_live (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .load_i     (commit),
    .load_val_i (shadow_time),
    .time_o     (live_time)
  );

endmodule

// File: tb/rtc_shadow_bank_tb_top.sv
module rtc_shadow_bank_tb_top;

  localparam int AW   = 17;
  localparam int BASE = (1 << AW) - 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic          sec_tick;
  logic          osc_stop;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rtc_shadow_bank #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sec_tick(sec_tick), .osc_stop(osc_stop)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    wr_raw(BASE + off, d);
  endtask

  task automatic rd_raw(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd_chk(input string tag, input int off, input logic [7:0] exp);
    logic [7:0] v;
    rd_raw(BASE + off, v);
    chk(tag, v, exp);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int dw,
                          input int h, input int mi, input int s);
    wr(0, 8'h80);
    wr(1, bcd(s)); wr(2, bcd(mi)); wr(3, bcd(h)); wr(4, bcd(dw));
    wr(5, bcd(d)); wr(6, bcd(mo)); wr(7, bcd(y));
    wr(0, 8'h00);
  endtask

  function automatic int last_day(input int y, input int m);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic roll(input int y, input int m);
    int dw, ld;
    dw = (y + m) % 7 + 1;
    ld = last_day(y, m);
    set_time(y, m, ld, dw, 23, 59, 59);
    tick();
    rd_chk("R7 date wraps after month length", 5, 8'h01);
    rd_chk("R8 month advance", 6, bcd(m == 12 ? 1 : m + 1));
    rd_chk("R8 year advance", 7, bcd(m == 12 ? (y + 1) % 100 : y));
    rd_chk("R8 day of week", 4, bcd(dw == 7 ? 1 : dw + 1));
    rd_chk("R6 hour wrap", 3, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; sec_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd_chk("R2 control", 0, 8'h00);
    rd_chk("R2 seconds with stop", 1, 8'h80);
    rd_chk("R2 minutes", 2, 8'h00);
    rd_chk("R2 hours", 3, 8'h00);
    rd_chk("R2 day", 4, 8'h01);
    rd_chk("R2 date", 5, 8'h01);
    rd_chk("R2 month", 6, 8'h01);
    rd_chk("R2 year", 7, 8'h00);
    chk("R2 osc_stop", {7'd0, osc_stop}, 8'h01);

    // R3 stop flag
    tick(); tick();
    rd_chk("R3 tick ignored while stopped", 1, 8'h80);
    wr(1, 8'h00);
    chk("R3 osc_stop cleared", {7'd0, osc_stop}, 8'h00);
    tick();
    rd_chk("R3 counting after stop cleared", 1, 8'h01);

    // R13 control readback
    wr(0, 8'h3F); rd_chk("R13 control readback", 0, 8'h3F);
    wr(0, 8'h15); rd_chk("R13 control readback", 0, 8'h15);
    wr(0, 8'h00);

    // R1 window decode
    wr_raw(BASE - 1, 8'hFF);
    rd_raw(BASE - 1, v); chk("R1 read below window", v, 8'h00);
    rd_raw(0, v);        chk("R1 read at address zero", v, 8'h00);
    rd_chk("R1 control untouched by outside write", 0, 8'h00);
    rd_chk("R1 seconds untouched by outside write", 1, 8'h01);

    // R4 forced-zero bits
    wr(0, 8'h80);
    for (int k = 1; k < 8; k++) wr(k, 8'hFF);
    rd_chk("R4 seconds", 1, 8'hFF);
    rd_chk("R4 minutes", 2, 8'h7F);
    rd_chk("R4 hours", 3, 8'h3F);
    rd_chk("R4 day", 4, 8'h07);
    rd_chk("R4 date", 5, 8'h3F);
    rd_chk("R4 month", 6, 8'h1F);
    rd_chk("R4 year", 7, 8'hFF);
    chk("R3 osc_stop set by seconds bit 7", {7'd0, osc_stop}, 8'h01);

    // R5 R6 seconds and minute sweep
    set_time(0, 1, 1, 1, 0, 0, 0);
    chk("R3 osc_stop after load", {7'd0, osc_stop}, 8'h00);
    for (int i = 1; i <= 130; i++) begin
      tick();
      rd_chk("R5 seconds sweep", 1, bcd(i % 60));
      rd_chk("R6 minute carry", 2, bcd(i / 60));
    end
    set_time(0, 1, 1, 1, 5, 59, 59); tick();
    rd_chk("R6 hour carry", 3, 8'h06); rd_chk("R6 minute wrap", 2, 8'h00);
    set_time(0, 1, 1, 1, 9, 59, 59); tick();
    rd_chk("R6 hour BCD carry", 3, 8'h10);

    // R9 READ freezes shadow, live keeps counting
    set_time(0, 1, 1, 1, 0, 0, 10);
    wr(0, 8'h40);
    tick(); tick(); tick();
    rd_chk("R9 frozen while READ set", 1, 8'h10);
    wr(0, 8'h00);
    tick();
    rd_chk("R9 live count after READ cleared", 1, 8'h14);

    // R12 halt in the same cycle as the tick does not cut the update
    @(negedge clk);
    sec_tick = 1'b1; addr = AW'(BASE); wr_data = 8'h40; wr_en = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    rd_chk("R12 update in progress completes", 1, 8'h15);
    tick();
    rd_chk("R12 halted afterwards", 1, 8'h15);
    wr(0, 8'h00); tick();
    rd_chk("R9 resumed count", 1, 8'h17);

    // R10 WRITE halt and commit
    wr(0, 8'h80);
    wr(1, 8'h30);
    tick();
    rd_chk("R10 no refresh while WRITE set", 1, 8'h30);
    @(negedge clk);
    sec_tick = 1'b1; addr = AW'(BASE); wr_data = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    tick();
    rd_chk("R10 committed and coincident tick discarded", 1, 8'h31);
    rd_chk("R10 minutes kept", 2, 8'h00);

    // R11 both halts set
    wr(0, 8'hC0);
    wr(1, 8'h45);
    tick();
    rd_chk("R11 no refresh with both set", 1, 8'h45);
    wr(0, 8'h80);
    tick();
    rd_chk("R11 no refresh after READ cleared alone", 1, 8'h45);
    wr(0, 8'h00);
    tick();
    rd_chk("R11 commit on WRITE clear", 1, 8'h46);

    // R7 R8 rollover sweeps
    for (int y = 0; y < 100; y++) roll(y, 2);
    for (int m = 1; m <= 12; m++) begin
      roll(1, m);
      roll(4, m);
    end
    roll(99, 12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule